// File: doc/BRIEF.md
# Multi-Cause Warm Reset Sequencer

This block issues warm resets in a two-processor system (a host processor and a DSP). Five causes can start a reset. Each cause drives its own subset of fifteen reset domains:

- a software write to the first control register;
- a host watchdog underflow;
- a DSP watchdog underflow;
- a host-only software request;
- a peripheral disable written to the second control register.

The domain outputs are active high. They stay asserted for a fixed hold window. When a cause resets the memory path and the SDRAM currently runs in auto-refresh, the block first asks the memory controller to move to self-refresh. It keeps the domains in reset until the controller acknowledges.

Each cause that has its own record sets a sticky bit in a cause register. Software reads the bit after the reset and clears it by writing one. A warm reset leaves these bits and the control settings untouched. Only the power-on reset input `por_n` returns them to their initial values.

The sequencer is a three-state machine:

- **ST_IDLE**: no domain is in reset. On any cause the transition **T_START** leads to **ST_HOLD**.
- **ST_HOLD**: the domains are held and the hold counter runs. A new cause takes **T_EXTEND**, which stays in ST_HOLD, widens the mask and reloads the counter. When the counter expires:
  - with no self-refresh request open, **T_RELEASE** leads to ST_IDLE;
  - with a request open and no acknowledge, **T_PARK** leads to **ST_WAIT_ACK**.
- **ST_WAIT_ACK**: the domains stay held. An acknowledge takes **T_ACKED** to ST_IDLE. A new cause takes **T_REARM** back to ST_HOLD.

Top module: `warm_rst_ctrl`

## Requirements
- R1: While `por_n` is low, and in the cycle after it rises, `dom_rst` is 0, `sr_req` is 0 and `cause` is 0. After power-on, `dsp_en` = 1, `per_en` = 1 and `wd_per_en` = 1.
- R2: A write to address 0 whose data has bit 3 set triggers a global software reset. So does a write to address 0 with bit 0 set and bit 1 clear. A global software reset asserts the global mask, `dom_rst` bits 0 through 10, and sets `cause` bit 1.
- R3: A host watchdog underflow pulse asserts the same global mask (bits 0 through 10) and sets `cause` bit 2.
- R4: A DSP watchdog underflow pulse asserts only `dom_rst` bits 12 and 13. It sets `cause` bit 0 and clears `wd_per_en`. A DSP watchdog underflow takes priority over a write to address 2 in the same cycle.
- R5: A write to address 0 with bits 0 and 1 set and bit 3 clear resets only the host processor (`dom_rst` bit 11) and sets `cause` bit 3. Every write to address 0 stores its bit 1 as `dsp_en`. Address 0 data with bits 0 and 3 both clear starts no reset.
- R6: A write to address 1 with bit 0 clear, while `per_en` is 1, asserts only `dom_rst` bits 9 and 14 and clears `per_en`. The same write while `per_en` is already 0 starts no reset. A write with bit 0 set sets `per_en` and starts no reset.
- R7: Unless a self-refresh acknowledge is still awaited, the domains of a cause stay asserted for exactly HOLD_CYC (default 16) cycles. The count starts at the clock edge that samples the cause. All domains then release together.
- R8: `sr_req` rises with a global software reset or a host watchdog reset only when `sdram_autoref` is 1. It then stays high until `sr_ack` is sampled. No domain is released while `sr_req` is high.
- R9: `cause` bits are sticky and survive the warm reset they record. A write to address 3 clears each bit written as 1. A cause arriving in the same cycle as the clear wins.
- R10: Causes arriving in the same cycle set every matching `cause` bit and assert the union of their domain masks.
- R11: A cause arriving while a reset is active ORs its mask into the held domains and restarts the hold window from its own edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control A, 1 control B, 2 DSP control, 3 cause (write 1 to clear) |
| reg_wdata | input | 4 | Register write data |
| host_wd_uflow | input | 1 | Host watchdog underflow pulse |
| dsp_wd_uflow | input | 1 | DSP watchdog underflow pulse |
| sdram_autoref | input | 1 | SDRAM is currently in auto-refresh mode |
| sr_ack | input | 1 | Memory controller acknowledges the self-refresh request |
| dom_rst | output | 15 | Domain resets. Bits 0 through 10 form the global mask: display, system DMA, host port interface, interconnect initiator, peripheral-bus controller, traffic controller, DSP MMU, host bridge and peripherals, shared peripherals, class 2 modules, class 3 modules. Bit 11 host processor, 12 DSP system, 13 DSP peripheral wrapper switches, 14 peripheral wrapper switches |
| sr_req | output | 1 | Request to switch SDRAM to self-refresh |
| dsp_en | output | 1 | Stored DSP enable (control A bit 1) |
| per_en | output | 1 | Stored peripheral enable (control B bit 0) |
| wd_per_en | output | 1 | Stored DSP watchdog peripheral enable (DSP control bit 1) |
| cause | output | 4 | Sticky reset cause: bit 0 DSP watchdog, bit 1 global software, bit 2 host watchdog, bit 3 host software |

## Verification
The assertions assume a well-behaved memory controller: `sr_ack` rises only while `sr_req` is high, and a watchdog underflow is a single-cycle pulse. They also assume that software does not rewrite the DSP control register in the same cycle as a DSP watchdog underflow. The stimulus raises `sr_ack` for one cycle only after it has seen `sr_req` high, and drops every underflow input on the next falling edge. It never combines a DSP control write with a DSP watchdog pulse. Every case waits for the domains to release before it starts the next one. The one exception is the re-trigger case, which deliberately overlaps two causes.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int NUM_DOM = 15;

    localparam int D_DISPLAY = 0;
    localparam int D_SYSDMA  = 1;
    localparam int D_HPORT   = 2;
    localparam int D_INIT    = 3;
    localparam int D_PBUS    = 4;
    localparam int D_TRAFFIC = 5;
    localparam int D_DSPMMU  = 6;
    localparam int D_HBRIDGE = 7;
    localparam int D_SHARED  = 8;
    localparam int D_CLS2    = 9;
    localparam int D_CLS3    = 10;
    localparam int D_HOSTCPU = 11;
    localparam int D_DSPSYS  = 12;
    localparam int D_DSPWRAP = 13;
    localparam int D_PERWRAP = 14;

    typedef logic [NUM_DOM-1:0] dom_vec_t;

    localparam logic [1:0] A_CTRL_A  = 2'd0;
    localparam logic [1:0] A_CTRL_B  = 2'd1;
    localparam logic [1:0] A_DSP_CTL = 2'd2;
    localparam logic [1:0] A_CAUSE   = 2'd3;

    // cause register bit positions
    localparam int C_DSP_WD  = 0;
    localparam int C_GLOB_SW = 1;
    localparam int C_HOST_WD = 2;
    localparam int C_HOST_SW = 3;

    typedef struct packed {
        logic per_off;
        logic host_sw;
        logic host_wd;
        logic glob_sw;
        logic dsp_wd;
    } rst_evt_t;

    function automatic dom_vec_t dom_bit(input int idx);
        return dom_vec_t'(1) << idx;
    endfunction

    localparam dom_vec_t M_GLOBAL =
        dom_bit(D_DISPLAY) | dom_bit(D_SYSDMA) | dom_bit(D_HPORT) |
        dom_bit(D_INIT) | dom_bit(D_PBUS) | dom_bit(D_TRAFFIC) |
        dom_bit(D_DSPMMU) | dom_bit(D_HBRIDGE) | dom_bit(D_SHARED) |
        dom_bit(D_CLS2) | dom_bit(D_CLS3);
    localparam dom_vec_t M_HOST   = dom_bit(D_HOSTCPU);
    localparam dom_vec_t M_DSP    = dom_bit(D_DSPSYS) | dom_bit(D_DSPWRAP);
    localparam dom_vec_t M_PERIPH = dom_bit(D_CLS2) | dom_bit(D_PERWRAP);

    function automatic dom_vec_t evt_mask(input rst_evt_t e);
        dom_vec_t m;
        m = '0;
        if (e.glob_sw || e.host_wd) m = m | M_GLOBAL;
        if (e.host_sw)              m = m | M_HOST;
        if (e.dsp_wd)               m = m | M_DSP;
        if (e.per_off)              m = m | M_PERIPH;
        return m;
    endfunction

endpackage

// File: rtl/rstc_regs.sv
module rstc_regs
    import rstc_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [3:0] reg_wdata,
    input  logic       host_wd_uflow,
    input  logic       dsp_wd_uflow,
    output rst_evt_t   evt,
    output logic       dsp_en,
    output logic       per_en,
    output logic       wd_per_en,
    output logic [3:0] cause
);

    logic       wr_a, wr_b, wr_d, wr_c;
    logic [3:0] cause_set;
    logic [3:0] cause_clr;

    assign wr_a = reg_we && (reg_addr == A_CTRL_A);
    assign wr_b = reg_we && (reg_addr == A_CTRL_B);
    assign wr_d = reg_we && (reg_addr == A_DSP_CTL);
    assign wr_c = reg_we && (reg_addr == A_CAUSE);

    // cause decode
    always_comb begin
        evt         = '0;
        evt.glob_sw = wr_a && (reg_wdata[3] || (reg_wdata[0] && !reg_wdata[1]));
        evt.host_sw = wr_a && reg_wdata[0] && reg_wdata[1] && !reg_wdata[3];
        evt.host_wd = host_wd_uflow;
        evt.dsp_wd  = dsp_wd_uflow;
        evt.per_off = wr_b && !reg_wdata[0] && per_en;
    end

    always_comb begin
        cause_set            = '0;
        cause_set[C_DSP_WD]  = evt.dsp_wd;
        cause_set[C_GLOB_SW] = evt.glob_sw;
        cause_set[C_HOST_WD] = evt.host_wd;
        cause_set[C_HOST_SW] = evt.host_sw;
        cause_clr            = wr_c ? reg_wdata : 4'd0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            dsp_en    <= 1'b1;
            per_en    <= 1'b1;
            wd_per_en <= 1'b1;
            cause     <= '0;
        end else begin
            if (wr_a) dsp_en <= reg_wdata[1];
            if (wr_b) per_en <= reg_wdata[0];
            if (evt.dsp_wd)
                wd_per_en <= 1'b0;
            else if (wr_d)
                wd_per_en <= reg_wdata[1];
            cause <= (cause & ~cause_clr) | cause_set;
        end
    end

endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic     clk,
    input  logic     por_n,
    input  rst_evt_t evt,
    input  logic     sdram_autoref,
    input  logic     sr_ack,
    output dom_vec_t dom_rst,
    output logic     sr_req
);

    localparam int CNT_W = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT_ACK
    } seq_st_t;

    seq_st_t          state_q, state_d;
    dom_vec_t         mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sr_q;
    dom_vec_t         new_mask;
    logic             any_evt;
    logic             want_sr;
    logic             cnt_done;

    assign new_mask = evt_mask(evt);
    assign any_evt  = |new_mask;
    assign want_sr  = (evt.glob_sw || evt.host_wd) && sdram_autoref;
    assign cnt_done = (cnt_q == '0);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_evt) state_d = ST_HOLD;                    // T_START
            end
            ST_HOLD: begin
                if (any_evt)
                    state_d = ST_HOLD;                             // T_EXTEND
                else if (cnt_done && sr_q && !sr_ack)
                    state_d = ST_WAIT_ACK;                         // T_PARK
                else if (cnt_done)
                    state_d = ST_IDLE;                             // T_RELEASE
            end
            ST_WAIT_ACK: begin
                if (any_evt)     state_d = ST_HOLD;                // T_REARM
                else if (sr_ack) state_d = ST_IDLE;                // T_ACKED
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mask_q <= '0;
            cnt_q  <= '0;
            sr_q   <= 1'b0;
        end else begin
            if (any_evt) begin
                mask_q <= mask_q | new_mask;
                cnt_q  <= CNT_LOAD;
            end else begin
                if (state_d == ST_IDLE) mask_q <= '0;
                if (state_q == ST_HOLD && !cnt_done) cnt_q <= cnt_q - 1'b1;
            end
            if (want_sr)     sr_q <= 1'b1;
            else if (sr_ack) sr_q <= 1'b0;
        end
    end

    assign dom_rst = mask_q;
    assign sr_req  = sr_q;

endmodule

// File: rtl/warm_rst_ctrl.sv
module warm_rst_ctrl
    import rstc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [3:0]  reg_wdata,
    input  logic        host_wd_uflow,
    input  logic        dsp_wd_uflow,
    input  logic        sdram_autoref,
    input  logic        sr_ack,
    output logic [14:0] dom_rst,
    output logic        sr_req,
    output logic        dsp_en,
    output logic        per_en,
    output logic        wd_per_en,
    output logic [3:0]  cause
);

    rst_evt_t evt;
    dom_vec_t dom_int;

    rstc_regs u_regs (
        .clk           (clk),
        .por_n         (por_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .host_wd_uflow (host_wd_uflow),
        .dsp_wd_uflow  (dsp_wd_uflow),
        .evt           (evt),
        .dsp_en        (dsp_en),
        .per_en        (per_en),
        .wd_per_en     (wd_per_en),
        .cause         (cause)
    );

    rstc_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk           (clk),
        .por_n         (por_n),
        .evt           (evt),
        .sdram_autoref (sdram_autoref),
        .sr_ack        (sr_ack),
        .dom_rst       (dom_int),
        .sr_req        (sr_req)
    );

    assign dom_rst = dom_int;

endmodule

// File: rtl/rstc_chk.sv
module rstc_chk
    import rstc_pkg::*;
(
    input logic        clk,
    input logic        por_n,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic        host_wd_uflow,
    input logic        dsp_wd_uflow,
    input logic        sr_ack,
    input logic [14:0] dom_rst,
    input logic        sr_req,
    input logic        wd_per_en,
    input logic [3:0]  cause
);

    AST_HWD_GLOBAL: assert property (@(posedge clk) disable iff (!por_n)
        host_wd_uflow |=> (((dom_rst & M_GLOBAL) == M_GLOBAL) && cause[C_HOST_WD])); // R3

    AST_DSPWD_EFFECT: assert property (@(posedge clk) disable iff (!por_n)
        dsp_wd_uflow |=> (!wd_per_en && cause[C_DSP_WD] && ((dom_rst & M_DSP) == M_DSP))); // R4

    AST_SR_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (sr_req && !sr_ack) |=> sr_req); // R8

    AST_SR_WITH_GLOBAL: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sr_req) |-> ((dom_rst & M_GLOBAL) == M_GLOBAL)); // R8

    AST_NO_RELEASE_PENDING: assert property (@(posedge clk) disable iff (!por_n)
        ((|$past(dom_rst)) && (dom_rst == '0)) |-> (!sr_req && (!$past(sr_req) || $past(sr_ack)))); // R8

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !(reg_we && (reg_addr == A_CAUSE)) |=> ((cause & $past(cause)) == $past(cause))); // R9

endmodule

bind warm_rst_ctrl rstc_chk u_chk (.*);

// File: tb/tb_warm_rst_ctrl.sv
module tb_warm_rst_ctrl;

    localparam int HOLD = 16;
    localparam logic [14:0] GLOB = 15'h07FF;
    localparam logic [14:0] HOSTM = 15'h0800;
    localparam logic [14:0] DSPM = 15'h3000;
    localparam logic [14:0] PERM = 15'h4200;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [3:0]  reg_wdata = 4'd0;
    logic        host_wd_uflow = 1'b0;
    logic        dsp_wd_uflow = 1'b0;
    logic        sdram_autoref = 1'b0;
    logic        sr_ack = 1'b0;
    logic [14:0] dom_rst;
    logic        sr_req, dsp_en, per_en, wd_per_en;
    logic [3:0]  cause;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    warm_rst_ctrl #(.HOLD_CYC(HOLD)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            report();
            $finish;
        end
    end

    // drive one cycle of stimulus at a falling edge, return at the next falling edge
    task automatic fire(input logic we, input logic [1:0] a, input logic [3:0] d,
                        input logic h, input logic w);
        reg_we = we; reg_addr = a; reg_wdata = d;
        host_wd_uflow = h; dsp_wd_uflow = w;
        @(negedge clk);
        reg_we = 1'b0; host_wd_uflow = 1'b0; dsp_wd_uflow = 1'b0;
    endtask

    // observe a whole reset window that started at the last sampled edge
    task automatic watch(input logic [14:0] m, input logic sr_exp, input string req);
        if (m == '0) begin
            for (int j = 0; j < 3; j++) begin
                chk(dom_rst == '0, req, "no reset expected", 32'(dom_rst), 0);
                chk(sr_req == 1'b0, "R8", "no sr_req expected", 32'(sr_req), 0);
                @(negedge clk);
            end
            return;
        end
        chk(dom_rst == m, req, "domains at start", 32'(dom_rst), 32'(m));
        chk(sr_req == sr_exp, "R8", "sr_req at start", 32'(sr_req), 32'(sr_exp));
        for (int j = 1; j < HOLD; j++) begin
            if (sr_exp && j == 3) sr_ack = 1'b1;
            if (j == 4) sr_ack = 1'b0;
            @(negedge clk);
            chk(dom_rst == m, "R7", "domains held", 32'(dom_rst), 32'(m));
        end
        sr_ack = 1'b0;
        @(negedge clk);
        chk(dom_rst == '0, "R7", "release after hold", 32'(dom_rst), 0);
        chk(sr_req == 1'b0, "R8", "sr_req low at release", 32'(sr_req), 0);
    endtask

    task automatic clear_cause();
        fire(1'b1, 2'd3, 4'hF, 1'b0, 1'b0);
        chk(cause == 4'd0, "R9", "cause cleared by W1C", 32'(cause), 0);
    endtask

    initial begin
        logic [14:0] m;
        logic [3:0]  ce;
        logic        g, hs;

        repeat (3) @(negedge clk);
        chk(dom_rst == '0 && sr_req == 1'b0 && cause == 4'd0, "R1", "outputs in reset",
            {dom_rst, sr_req, cause}, 0);
        por_n = 1'b1;
        @(negedge clk);
        chk(dom_rst == '0, "R1", "dom_rst after reset", 32'(dom_rst), 0);
        chk(cause == 4'd0, "R1", "cause after reset", 32'(cause), 0);
        chk({dsp_en, per_en, wd_per_en} == 3'b111, "R1", "enables after reset",
            32'({dsp_en, per_en, wd_per_en}), 32'h7);

        // sweep of every control-A write value
        for (int v = 0; v < 16; v++) begin
            logic [3:0] d;
            d = 4'(v);
            sdram_autoref = d[2];
            g  = d[3] | (d[0] & ~d[1]);
            hs = d[0] & d[1] & ~d[3];
            m  = (g ? GLOB : 15'd0) | (hs ? HOSTM : 15'd0);
            ce = {hs, 1'b0, g, 1'b0};
            fire(1'b1, 2'd0, d, 1'b0, 1'b0);
            chk(dsp_en == d[1], "R5", "dsp_en stored", 32'(dsp_en), 32'(d[1]));
            watch(m, g & d[2], g ? "R2" : (hs ? "R5" : "R5"));
            chk(cause == ce, g ? "R2" : "R5", "cause after control A write", 32'(cause), 32'(ce));
            clear_cause();
        end

        // watchdog combinations with and without auto-refresh
        for (int c = 1; c < 4; c++) begin
            for (int ar = 0; ar < 2; ar++) begin
                logic h, w;
                h = c[1]; w = c[0];
                sdram_autoref = ar[0];
                m  = (h ? GLOB : 15'd0) | (w ? DSPM : 15'd0);
                ce = {1'b0, h, 1'b0, w};
                fire(1'b0, 2'd0, 4'd0, h, w);
                chk(wd_per_en == !w, "R4", "wd_per_en after watchdog", 32'(wd_per_en), 32'(!w));
                watch(m, h & ar[0], (h && w) ? "R10" : (h ? "R3" : "R4"));
                chk(cause == ce, h ? "R3" : "R4", "cause after watchdog", 32'(cause), 32'(ce));
                fire(1'b1, 2'd2, 4'h2, 1'b0, 1'b0);
                chk(wd_per_en == 1'b1, "R4", "wd_per_en rewritten", 32'(wd_per_en), 1);
                clear_cause();
            end
        end

        // peripheral disable
        sdram_autoref = 1'b0;
        fire(1'b1, 2'd1, 4'h0, 1'b0, 1'b0);
        chk(per_en == 1'b0, "R6", "per_en cleared", 32'(per_en), 0);
        watch(PERM, 1'b0, "R6");
        chk(cause == 4'd0, "R6", "no cause for peripheral reset", 32'(cause), 0);
        fire(1'b1, 2'd1, 4'h0, 1'b0, 1'b0);
        watch('0, 1'b0, "R6");
        fire(1'b1, 2'd1, 4'h1, 1'b0, 1'b0);
        chk(per_en == 1'b1, "R6", "per_en set", 32'(per_en), 1);
        watch('0, 1'b0, "R6");

        // late acknowledge holds the domains
        sdram_autoref = 1'b1;
        fire(1'b1, 2'd0, 4'h8, 1'b0, 1'b0);
        for (int j = 0; j < HOLD + 4; j++) begin
            chk(dom_rst == GLOB, "R8", "held while ack awaited", 32'(dom_rst), 32'(GLOB));
            chk(sr_req == 1'b1, "R8", "sr_req held", 32'(sr_req), 1);
            @(negedge clk);
        end
        sr_ack = 1'b1;
        @(negedge clk);
        sr_ack = 1'b0;
        chk(dom_rst == '0, "R8", "release after ack", 32'(dom_rst), 0);
        chk(sr_req == 1'b0, "R8", "sr_req dropped after ack", 32'(sr_req), 0);
        clear_cause();

        // auto-refresh off: no request
        sdram_autoref = 1'b0;
        fire(1'b1, 2'd0, 4'h8, 1'b0, 1'b0);
        watch(GLOB, 1'b0, "R8");
        clear_cause();

        // re-trigger during an active window
        fire(1'b0, 2'd0, 4'd0, 1'b0, 1'b1);
        for (int j = 0; j < 5; j++) begin
            chk(dom_rst == DSPM, "R11", "first cause held", 32'(dom_rst), 32'(DSPM));
            @(negedge clk);
        end
        fire(1'b1, 2'd0, 4'h3, 1'b0, 1'b0);
        watch(DSPM | HOSTM, 1'b0, "R11");
        chk(cause == 4'b1001, "R11", "both causes recorded", 32'(cause), 32'h9);
        fire(1'b1, 2'd2, 4'h2, 1'b0, 1'b0);
        clear_cause();

        // simultaneous causes
        fire(1'b1, 2'd0, 4'h8, 1'b1, 1'b1);
        watch(GLOB | DSPM, 1'b0, "R10");
        chk(cause == 4'b0111, "R10", "union of causes", 32'(cause), 32'h7);

        // clear and set in the same cycle: set wins, survives the warm reset
        fire(1'b1, 2'd3, 4'hF, 1'b0, 1'b1);
        chk(cause == 4'b0001, "R9", "set beats clear", 32'(cause), 32'h1);
        watch(DSPM, 1'b0, "R4");
        chk(cause == 4'b0001, "R9", "cause survives warm reset", 32'(cause), 32'h1);
        fire(1'b1, 2'd3, 4'h2, 1'b0, 1'b0);
        chk(cause == 4'b0001, "R9", "clear of other bit leaves bit 0", 32'(cause), 32'h1);
        clear_cause();

        done = 1'b1;
        report();
        $finish;
    end

endmodule